// File: doc/BRIEF.md
# Interrupt and DMA Priority Encoder

This block chooses one winner among the internal requests of a serial bus controller. Two DMA request lines (transmit and receive) and four interrupt event groups compete. The block presents exactly one winner at a time. The four groups are error/abort, end-of-data/end-of-frame, receive-ready/receive-end and transmit-ready/transmit-end. The winner appears on a one-hot grant bus, and a request-valid flag is raised with it. The choice is purely combinational from the pending lines, so a new winner shows in the same cycle its request appears.

A mode input selects one of two fixed orders. The suspend order lets error/abort events pre-empt both DMA channels. The normal order keeps DMA on top.

An 8-bit level register holds a 3-bit system priority in its top three bits. Level 0 is the most urgent. Level 7 silences the block entirely.

The block also holds an 8-bit interrupt vector:
- The upper five bits are written by software.
- Bits 2:1 carry the code of the winning event group. They are captured on an interrupt acknowledge and stay fixed while the interrupt is serviced.
- Bit 0 is always zero.

Top module: `irq_dma_prio_top`

## Requirements
- R1: After synchronous reset the level register reads 8'h10 and the vector reads 8'h00.
- R2: With the mode input low, the order from highest to lowest is: transmit DMA, receive DMA, error/abort, end-of-data/end-of-frame, receive-ready/receive-end, transmit-ready/transmit-end.
- R3: With the mode input high, error/abort ranks above transmit DMA. The order of the other five sources is the same as in R2.
- R4: The grant bus is one-hot when any source is pending and the level is not 7. In that case req_valid is 1. Otherwise grant is all zero and req_valid is 0. Grant bit positions are: 0 transmit DMA, 1 receive DMA, 2 error/abort, 3 end-of-data/end-of-frame, 4 receive-ready/receive-end, 5 transmit-ready/transmit-end. The same group order applies to evt_req bits 0 to 3.
- R5: When the level field (level register bits 7:5) equals 7, req_valid and grant are zero whatever is pending.
- R6: A level write replaces the whole level register on the next clock. prio_level always shows bits 7:5 of that register.
- R7: A vector write replaces vector bits 7:3 on the next clock. Bits 2:0 are left unchanged by the write.
- R8: On a clock with ack high, req_valid high and an event group winning, vector bits 2:1 take that group's code. The codes are 00 error/abort, 01 end-of-data/end-of-frame, 10 receive-ready/receive-end and 11 transmit-ready/transmit-end.
- R9: An ack while a DMA channel wins, or while req_valid is low, leaves vector bits 2:1 unchanged. With neither ack nor a vector write, the whole vector holds its value.
- R10: Vector bit 0 is always 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| susp_mode | input | 1 | 1 selects the order where errors pre-empt DMA |
| tx_dma_req | input | 1 | Transmit DMA request pending |
| rx_dma_req | input | 1 | Receive DMA request pending |
| evt_req | input | 4 | Event group pending lines (bit order as in R4) |
| ack | input | 1 | Interrupt acknowledge; latches the group code |
| lvl_wr_en | input | 1 | Level register write strobe |
| lvl_wr_data | input | 8 | Level register write data |
| vec_wr_en | input | 1 | Vector base write strobe |
| vec_wr_data | input | 8 | Vector write data (bits 7:3 used) |
| req_valid | output | 1 | A winner exists and the block is not silenced |
| grant | output | 6 | One-hot winner |
| prio_level | output | 3 | System priority level field |
| level_q | output | 8 | Level register contents |
| vector | output | 8 | Interrupt vector |

## Verification
A wrong rank table or a wrong mode decode shows at once on grant, in the same cycle as the offending request pattern. Random patterns with several sources pending at the same time expose such a fault within a handful of cycles. A bad code capture, or a capture at the wrong moment, shows on vector bits 2:1 one clock after the acknowledge. The fault then persists until the next valid acknowledge, so every later check of the vector reveals it. A corrupted level register shows directly on level_q and prio_level. When that corruption produces level 7, it also shows as a missing req_valid.

// File: rtl/irq_prio_pkg.sv
package irq_prio_pkg;
    localparam int NUM_SRC   = 6;
    localparam int NUM_GRP   = 4;
    localparam int REG_W     = 8;
    localparam int LVL_W     = 3;
    localparam int CODE_W    = 2;
    localparam int BASE_W    = REG_W - CODE_W - 1;
    localparam logic [REG_W-1:0] LVL_RESET = 8'h10;
    localparam logic [LVL_W-1:0] LVL_MUTE  = '1;

    typedef enum logic [2:0] {
        SRC_TXDMA = 3'd0,
        SRC_RXDMA = 3'd1,
        SRC_ERR   = 3'd2,
        SRC_EOD   = 3'd3,
        SRC_RXRDY = 3'd4,
        SRC_TXRDY = 3'd5
    } src_e;

    typedef struct packed {
        logic valid;
        src_e src;
    } win_t;

    function automatic logic is_event(input src_e s);
        return (s != SRC_TXDMA) && (s != SRC_RXDMA);
    endfunction

    function automatic logic [CODE_W-1:0] group_code(input src_e s);
        case (s)
            SRC_ERR:   return 2'b00;
            SRC_EOD:   return 2'b01;
            SRC_RXRDY: return 2'b10;
            default:   return 2'b11;
        endcase
    endfunction

    // rank 0 is the most urgent
    function automatic src_e rank_to_src(input int rank, input logic susp);
        if (susp) begin
            case (rank)
                0: return SRC_ERR;
                1: return SRC_TXDMA;
                2: return SRC_RXDMA;
                3: return SRC_EOD;
                4: return SRC_RXRDY;
                default: return SRC_TXRDY;
            endcase
        end
        return src_e'(rank[2:0]);
    endfunction
endpackage

// File: rtl/irq_prio_select.sv
module irq_prio_select
    import irq_prio_pkg::*;
#(
    parameter int N = NUM_SRC
) (
    input  logic [N-1:0] pend,
    input  logic         susp,
    input  logic         mute,
    output win_t         win,
    output logic [N-1:0] grant
);
    always_comb begin
        win = '{valid: 1'b0, src: SRC_TXDMA};
        for (int r = N - 1; r >= 0; r--) begin
            if (pend[rank_to_src(r, susp)]) begin
                win.valid = 1'b1;
                win.src   = rank_to_src(r, susp);
            end
        end
        if (mute) win.valid = 1'b0;
    end

    for (genvar g = 0; g < N; g++) begin : g_grant
        assign grant[g] = win.valid && (win.src == src_e'(g));
    end
endmodule

// File: rtl/irq_level_reg.sv
module irq_level_reg
    import irq_prio_pkg::*;
#(
    parameter int W = REG_W,
    parameter logic [W-1:0] RST_VAL = LVL_RESET
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         wr_en,
    input  logic [W-1:0] wr_data,
    output logic [W-1:0] q
);
    always_ff @(posedge clk) begin
        if (rst)        q <= RST_VAL;
        else if (wr_en) q <= wr_data;
    end
endmodule

// File: rtl/irq_vector_reg.sv
module irq_vector_reg
    import irq_prio_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wr_data,
    input  logic             ack,
    input  win_t             win,
    output logic [REG_W-1:0] vec
);
    logic [BASE_W-1:0] base_q;
    logic [CODE_W-1:0] code_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            base_q <= '0;
            code_q <= '0;
        end else begin
            if (wr_en) base_q <= wr_data[REG_W-1 -: BASE_W];
            if (ack && win.valid && is_event(win.src))
                code_q <= group_code(win.src);
        end
    end

    assign vec = {base_q, code_q, 1'b0};
endmodule

// File: rtl/irq_dma_prio_top.sv
module irq_dma_prio_top
    import irq_prio_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             susp_mode,
    input  logic             tx_dma_req,
    input  logic             rx_dma_req,
    input  logic [3:0]       evt_req,
    input  logic             ack,
    input  logic             lvl_wr_en,
    input  logic [7:0]       lvl_wr_data,
    input  logic             vec_wr_en,
    input  logic [7:0]       vec_wr_data,
    output logic             req_valid,
    output logic [5:0]       grant,
    output logic [2:0]       prio_level,
    output logic [7:0]       level_q,
    output logic [7:0]       vector
);
    win_t               win;
    logic [NUM_SRC-1:0] pend;

    assign pend = {evt_req, rx_dma_req, tx_dma_req};

    irq_level_reg u_level (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (lvl_wr_en),
        .wr_data (lvl_wr_data),
        .q       (level_q)
    );

    assign prio_level = level_q[REG_W-1 -: LVL_W];

    irq_prio_select #(.N(NUM_SRC)) u_sel (
        .pend  (pend),
        .susp  (susp_mode),
        .mute  (prio_level == LVL_MUTE),
        .win   (win),
        .grant (grant)
    );

    assign req_valid = win.valid;

    irq_vector_reg u_vec (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (vec_wr_en),
        .wr_data (vec_wr_data),
        .ack     (ack),
        .win     (win),
        .vec     (vector)
    );
endmodule

// File: rtl/irq_dma_prio_chk.sv
module irq_dma_prio_chk (
    input logic       clk,
    input logic       rst,
    input logic       susp_mode,
    input logic       tx_dma_req,
    input logic       rx_dma_req,
    input logic [3:0] evt_req,
    input logic       ack,
    input logic       vec_wr_en,
    input logic       lvl_wr_en,
    input logic [7:0] lvl_wr_data,
    input logic       req_valid,
    input logic [5:0] grant,
    input logic [2:0] prio_level,
    input logic [7:0] level_q,
    input logic [7:0] vector
);
    // R4
    grant_onehot_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(grant) && (req_valid == (grant != 6'd0)));

    // R5
    mute_level_chk: assert property (@(posedge clk) disable iff (rst)
        (prio_level == 3'd7) |-> (!req_valid && grant == 6'd0));

    // R3
    susp_err_first_chk: assert property (@(posedge clk) disable iff (rst)
        (susp_mode && evt_req[0] && prio_level != 3'd7) |-> grant == 6'b000100);

    // R2
    normal_tx_first_chk: assert property (@(posedge clk) disable iff (rst)
        (!susp_mode && tx_dma_req && prio_level != 3'd7) |-> grant == 6'b000001);

    // R10
    vec_bit0_chk: assert property (@(posedge clk) disable iff (rst)
        vector[0] == 1'b0);

    // R9
    vec_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!ack && !vec_wr_en) |=> $stable(vector));

    // R6
    level_write_chk: assert property (@(posedge clk) disable iff (rst)
        lvl_wr_en |=> (level_q == $past(lvl_wr_data)));
endmodule

bind irq_dma_prio_top irq_dma_prio_chk u_chk (.*);

// File: tb/tb_irq_dma_prio_top.sv
module tb_irq_dma_prio_top;
    logic       clk = 1'b0;
    logic       rst;
    logic       susp_mode, tx_dma_req, rx_dma_req, ack;
    logic [3:0] evt_req;
    logic       lvl_wr_en, vec_wr_en;
    logic [7:0] lvl_wr_data, vec_wr_data;
    logic       req_valid;
    logic [5:0] grant;
    logic [2:0] prio_level;
    logic [7:0] level_q, vector;

    int checks = 0;
    int fails  = 0;
    logic [7:0] m_level;
    logic [4:0] m_base;
    logic [1:0] m_code;

    always #2.5 clk = ~clk;

    irq_dma_prio_top dut (.*);

    initial begin
        #1000000;
        fails++;
        checks++;
        $display("FAIL watchdog: run did not finish, actual hung expected done");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    function automatic logic [5:0] exp_grant(input logic t, input logic r,
                                             input logic [3:0] e, input logic s,
                                             input logic [2:0] lvl);
        logic [5:0] p;
        p = {e, r, t};
        if (lvl == 3'd7) return 6'd0;
        if (s && p[2]) return 6'b000100;
        for (int i = 0; i < 6; i++)
            if (p[i]) return 6'd1 << i;
        return 6'd0;
    endfunction

    function automatic logic [1:0] code_of(input logic [5:0] g);
        case (g)
            6'b000100: return 2'b00;
            6'b001000: return 2'b01;
            6'b010000: return 2'b10;
            default:   return 2'b11;
        endcase
    endfunction

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic idle();
        {susp_mode, tx_dma_req, rx_dma_req, ack, lvl_wr_en, vec_wr_en} = '0;
        evt_req = '0; lvl_wr_data = '0; vec_wr_data = '0;
    endtask

    // drive at negedge, check combinational outputs, then clock and update model
    task automatic step(input string tag);
        logic [5:0] eg;
        #1;
        eg = exp_grant(tx_dma_req, rx_dma_req, evt_req, susp_mode, m_level[7:5]);
        chk({tag, " grant"}, {2'b00, grant}, {2'b00, eg});
        chk({tag, " req_valid"}, {7'd0, req_valid}, {7'd0, eg != 6'd0});
        @(posedge clk);
        if (ack && eg != 6'd0 && eg[1:0] == 2'b00) m_code = code_of(eg);
        if (vec_wr_en) m_base = vec_wr_data[7:3];
        if (lvl_wr_en) m_level = lvl_wr_data;
        @(negedge clk);
        chk("R7 R8 R9 R10 vector", vector, {m_base, m_code, 1'b0});
        chk("R6 level", level_q, m_level);
        chk("R6 prio_level", {5'd0, prio_level}, {5'd0, m_level[7:5]});
    endtask

    initial begin
        void'($urandom(32'd1234));
        idle();
        rst = 1'b1;
        m_level = 8'h10; m_base = '0; m_code = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        chk("R1 level reset", level_q, 8'h10);
        chk("R1 vector reset", vector, 8'h00);

        // R2: all pending, normal order -> transmit DMA
        tx_dma_req = 1; rx_dma_req = 1; evt_req = 4'hF; step("R2 all");
        // R3: suspend order -> error/abort
        susp_mode = 1; ack = 1; step("R3 susp all");
        // R8: codes for each group
        idle(); ack = 1; evt_req = 4'b1000; step("R8 txrdy");
        evt_req = 4'b0100; step("R8 rxrdy");
        evt_req = 4'b0010; step("R8 eod");
        // R9: DMA wins, ack ignored
        rx_dma_req = 1; evt_req = 4'b1000; step("R9 dma ack");
        // R9: nothing pending
        idle(); ack = 1; step("R9 empty ack");
        // R7: write sets base only
        idle(); vec_wr_en = 1; vec_wr_data = 8'hFF; step("R7 vec wr");
        // R5: mute level
        idle(); lvl_wr_en = 1; lvl_wr_data = 8'hE0; step("R6 mute wr");
        idle(); ack = 1; tx_dma_req = 1; evt_req = 4'hF; step("R5 muted");
        idle(); lvl_wr_en = 1; lvl_wr_data = 8'h00; step("R6 level 0");

        for (int n = 0; n < 400; n++) begin
            logic [31:0] r;
            r = $urandom;
            susp_mode   = r[0];
            tx_dma_req  = r[1] & r[2];
            rx_dma_req  = r[3] & r[4];
            evt_req     = r[8:5];
            ack         = r[9];
            vec_wr_en   = r[10] & r[11];
            vec_wr_data = r[19:12];
            lvl_wr_en   = (r[23:20] == 4'd0);
            lvl_wr_data = r[31:24];
            step("R2 R3 R4 R5 random");
        end

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule